// File: doc/BRIEF.md
# Mode-Selected Clock Divider Tree

This block derives seven clock outputs from one fast tick clock: a host clock, a half-rate host clock, a hub-link clock, a PCI clock, a USB clock, a reference clock and an interrupt-controller clock. A 3-bit mode code picks one of several operating points. These are two normal operating points with different host-to-hub ratios, two variants of those with the USB domain turned off, a test point built only from power-of-two divisions, and a setting that floats every output.

Each output is a registered square wave. Its high and low halves are a fixed number of ticks long, and that count depends on the lane and the mode. One free-running frame counter of `FRAME` ticks gives the common time base. Every running lane is forced high on the tick that opens a frame, so all rising edges line up at the frame boundary. A new mode code is taken only at a frame boundary. Because of this, a change of mode can never shorten a pulse.

In test mode one tick is half a period of the test clock. The reference output then runs at the test clock rate, and every other output runs at a power-of-two fraction of it. In the normal modes, one tick models 1/800 µs.

Top module: `clkdiv_tree`

## Requirements
- R1: While `rst_ni` is low, every clock output is high-impedance. Reset sets the frame position to 0 and the held mode to 000. The first mode code is taken at the end of the first frame.
- R2: Modes 000, 001 and 101 float all seven outputs (Z).
- R3: `mode_i` is sampled only on the clock edge that leaves frame position `FRAME-1`. Values presented at any other time have no effect on the outputs.
- R4: Mode 100 is test mode. The half-periods in ticks are: host 2, half-host 4, hub 4, PCI 8, USB 2, reference 1, interrupt 16.
- R5: Mode 011 is normal with the lower host rate. The half-periods in ticks are: host 4, half-host 8, hub 6, PCI 12, USB 8, reference 24, interrupt 24. The host therefore runs at 1.5 times the hub rate.
- R6: Mode 111 is normal with the higher host rate. The half-periods in ticks are: host 3, half-host 6, hub 6, PCI 12, USB 8, reference 24, interrupt 24. The host therefore runs at twice the hub rate.
- R7: Mode 010 behaves like 011 and mode 110 behaves like 111, except that in both the USB output is driven low.
- R8: At frame position p, a running output with half-period H is high exactly when (p mod 2H) < H. Every running output is therefore high at position 0.
- R9: In every running mode the half-host output has exactly twice the host period, and it rises only on a tick where the host output also rises.
- R10: The frame is `FRAME` = 96 ticks long, and the position wraps from 95 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock (two ticks per test-clock period) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode code, sampled at frame wrap |
| host_o | output | 1 | Host clock |
| host_half_o | output | 1 | Half-rate host clock |
| hub_o | output | 1 | Hub-link clock |
| pci_o | output | 1 | PCI clock |
| usb_o | output | 1 | USB clock |
| ref_o | output | 1 | Reference clock |
| apic_o | output | 1 | Interrupt-controller clock |

## Verification
A frame counter that is off by one shows up within one tick: the reference output in test mode toggles every tick and falls out of phase with the bench's own frame position. A mode register that loads mid-frame changes some output's half-period. This is visible before the next frame boundary, because the bench drives random codes on every tick that is not a wrap. A lane whose phase count is wrong breaks the rule that every running output is high at position 0, and this shows up no later than the following frame start.

// File: rtl/clkdiv_tree_pkg.sv
package clkdiv_tree_pkg;
  localparam int NUM_LANES = 7;
  localparam int L_HOST = 0, L_HALF = 1, L_HUB = 2, L_PCI = 3, L_USB = 4, L_REF = 5, L_APIC = 6;

  typedef enum logic [2:0] {
    K_OFF, K_TEST, K_LO, K_HI, K_LO_NOUSB, K_HI_NOUSB
  } kind_e;

  function automatic kind_e decode_mode(logic [2:0] m);
    case (m)
      3'b011:  return K_LO;
      3'b111:  return K_HI;
      3'b010:  return K_LO_NOUSB;
      3'b110:  return K_HI_NOUSB;
      3'b100:  return K_TEST;
      default: return K_OFF;
    endcase
  endfunction

  // half-period in ticks; 0 = lane idle
  function automatic int unsigned half_ticks(kind_e k, int lane);
    int unsigned t_test [NUM_LANES] = '{2, 4, 4, 8, 2, 1, 16};
    int unsigned t_lo   [NUM_LANES] = '{4, 8, 6, 12, 8, 24, 24};
    int unsigned t_hi   [NUM_LANES] = '{3, 6, 6, 12, 8, 24, 24};
    case (k)
      K_TEST:             return t_test[lane];
      K_LO, K_LO_NOUSB:   return t_lo[lane];
      K_HI, K_HI_NOUSB:   return t_hi[lane];
      default:            return 0;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_tree_frame.sv
module clkdiv_tree_frame
  import clkdiv_tree_pkg::*;
#(
  parameter int FRAME = 96,
  parameter int CW    = $clog2(FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output kind_e         kind_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    mode_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;
  assign kind_o = decode_mode(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 3'b000;
    end else begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      if (wrap_o) mode_q <= mode_i;
    end
  end

  // R3: held mode moves only at a frame boundary
  a_r3_mode_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(mode_q));
  // R10: frame position returns to zero after the last tick
  a_r10_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_tree_lane.sv
module clkdiv_tree_lane #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic [CW-1:0] half_i,
  output logic          lvl_o
);
  logic [CW-1:0] ph_q;
  logic          lvl_q;
  logic          run;

  assign run   = (half_i != '0);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      lvl_q <= 1'b1;
    end else if (wrap_i) begin
      ph_q  <= '0;
      lvl_q <= 1'b1;
    end else if (run) begin
      if (ph_q == half_i - 1'b1) begin
        ph_q  <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // R8: every lane opens a frame high
  a_r8_high_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> lvl_q);
  // R8: phase count stays inside the half-period
  a_r8_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (ph_q < half_i));
endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
  import clkdiv_tree_pkg::*;
#(
  parameter int FRAME = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  output logic       host_o,
  output logic       host_half_o,
  output logic       hub_o,
  output logic       pci_o,
  output logic       usb_o,
  output logic       ref_o,
  output logic       apic_o
);
  localparam int CW = $clog2(FRAME);

  logic [CW-1:0]        cnt;
  logic                 wrap;
  kind_e                kind;
  logic [NUM_LANES-1:0] lvl, val, drv_en;
  logic                 usb_off;

  clkdiv_tree_frame #(.FRAME(FRAME), .CW(CW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .cnt_o(cnt), .wrap_o(wrap), .kind_o(kind)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [CW-1:0] half;
    assign half = CW'(half_ticks(kind, i));
    clkdiv_tree_lane #(.CW(CW)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap),
      .half_i(half), .lvl_o(lvl[i])
    );
  end

  assign usb_off = (kind == K_LO_NOUSB) || (kind == K_HI_NOUSB);

  always_comb begin
    val         = lvl;
    val[L_USB]  = lvl[L_USB] & ~usb_off;
    drv_en      = (kind == K_OFF) ? '0 : '1;
  end

  assign host_o      = drv_en[L_HOST] ? val[L_HOST] : 1'bz;
  assign host_half_o = drv_en[L_HALF] ? val[L_HALF] : 1'bz;
  assign hub_o       = drv_en[L_HUB]  ? val[L_HUB]  : 1'bz;
  assign pci_o       = drv_en[L_PCI]  ? val[L_PCI]  : 1'bz;
  assign usb_o       = drv_en[L_USB]  ? val[L_USB]  : 1'bz;
  assign ref_o       = drv_en[L_REF]  ? val[L_REF]  : 1'bz;
  assign apic_o      = drv_en[L_APIC] ? val[L_APIC] : 1'bz;

  // R9: half-host edge never rises without a host rise
  a_r9_half_with_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl[L_HALF]) |-> $rose(lvl[L_HOST]));
  // R8: frame start finds every lane high
  a_r8_aligned_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> (&lvl));
endmodule

// File: tb/sim_clkdiv_tree.sv
module sim_clkdiv_tree;
  localparam int PERIOD = 10;
  localparam int FRAME  = 96;
  localparam int NFRAME = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  wire host, half, hub, pci, usb, refc, apic;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkdiv_tree #(.FRAME(FRAME)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .host_o(host), .host_half_o(half), .hub_o(hub), .pci_o(pci),
    .usb_o(usb), .ref_o(refc), .apic_o(apic)
  );

  // half-period per lane from R2, R4-R7; 0 = Z, -1 = held low
  function automatic int hv(logic [2:0] m, int lane);
    int t4[7] = '{2, 4, 4, 8, 2, 1, 16};
    int t5[7] = '{4, 8, 6, 12, 8, 24, 24};
    int t6[7] = '{3, 6, 6, 12, 8, 24, 24};
    case (m)
      3'b100: return t4[lane];
      3'b011: return t5[lane];
      3'b111: return t6[lane];
      3'b010: return (lane == 4) ? -1 : t5[lane];
      3'b110: return (lane == 4) ? -1 : t6[lane];
      default: return 0;
    endcase
  endfunction

  function automatic logic expv(logic [2:0] m, int lane, int p);
    int h = hv(m, lane);
    if (h == 0) return 1'bz;
    if (h < 0)  return 1'b0;
    return ((p % (2*h)) < h) ? 1'b1 : 1'b0;
  endfunction

  function automatic string tag_of(logic [2:0] m, int lane, int p);
    if (hv(m, lane) == 0) return "R2";
    if (p == 0)           return "R3 R8 R10";
    if (lane == 1)        return "R9";
    case (m)
      3'b100: return "R4";
      3'b011: return "R5";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_all(logic [2:0] m, int p, bit in_reset);
    logic [6:0] act;
    act = {apic, refc, usb, pci, hub, half, host};
    for (int l = 0; l < 7; l++) begin
      logic e;
      string t;
      e = expv(m, l, p);
      t = in_reset ? "R1" : tag_of(m, l, p);
      n_cmp++;
      if (act[l] !== e) begin
        n_bad++;
        $display("FAIL %s lane %0d mode %b pos %0d: got %b expected %b", t, l, m, p, act[l], e);
      end
    end
  endtask

  initial begin
    logic [2:0] m_model;
    logic [2:0] seq[8] = '{3'b011, 3'b111, 3'b100, 3'b010, 3'b110, 3'b000, 3'b001, 3'b101};
    int p;
    int fidx;
    void'($urandom(32'd4242));
    // R1: outputs float during reset
    repeat (3) begin
      @(negedge clk);
      check_all(3'b000, 0, 1'b1);
    end
    rst_n   = 1'b1;
    m_model = 3'b000;
    p       = 0;
    fidx    = 0;
    check_all(m_model, p, 1'b0);
    for (int c = 0; c < FRAME * NFRAME; c++) begin
      if (p == FRAME - 1) begin
        mode = (fidx < 8) ? seq[fidx] : 3'($urandom % 8);
        fidx++;
      end else begin
        mode = 3'($urandom % 8); // R3: mid-frame junk must be ignored
      end
      @(posedge clk);
      if (p == FRAME - 1) m_model = mode;
      p = (p + 1) % FRAME;
      @(negedge clk);
      check_all(m_model, p, 1'b0);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule